// File: doc/BRIEF.md
# Flash Bus Write Guard and Reset Sequencer

This block sits between the external control pins of a parallel NOR-style flash device and its internal command logic. It watches chip-enable, output-enable and write-enable, all active low, together with an active-low hardware reset pin, a supply-lockout flag and a power-on reset. From these it decides which bus writes may reach the command register and when the data pins may drive. All pins are taken to be synchronous to the single system clock, and every timing is a count of clock edges.

A bus write is passed on only when it is long enough to rule out a glitch. It must also start while the device can accept commands, and it must end cleanly by a rising chip-enable or write-enable. The block then issues a one-cycle strobe that carries the address and data held on the last active edge. A hardware reset that stays low long enough sends the internal state machine back to read mode and aborts any program or erase in progress. The data pins stay undriven while the reset pin is low, and reads stay blocked until a wake-up interval has passed. The same interval follows power-on reset. A supply lockout aborts work, forces read mode and discards writes.

Top module: `flash_guard`

## Requirements
- R1: While `por_n` is low, `ready`, `dq_oe` and `wr_stb` are 0 and `force_read` is 1. `force_read` falls at the first clock edge after `por_n` rises, unless a reset or lockout event raises it again.
- R2: A write is active on an edge when `ce_n`=0, `we_n`=0 and `oe_n`=1. Suppose the write stays active for at least GLITCH_CYC+1 consecutive edges and is then ended on an edge by `ce_n` or `we_n` going high while `oe_n` stays 1. Then `wr_stb` is 1 for exactly the one cycle after that ending edge. `wr_addr` and `wr_data` then show `addr` and `data` as they were on the last active edge.
- R3: No strobe results from a write active for GLITCH_CYC edges or fewer. No strobe results from a write that ends because `oe_n` falls.
- R4: A write counts only if it became active on an edge at which writes were enabled and it was inactive on the edge before. A write already held active through power-up or through a disabled period therefore never strobes.
- R5: When `rst_n` is low on RST_MIN_CYC consecutive edges, `force_read` pulses for one cycle and `abort_op` is 1 from then until `rst_n` rises. A shorter low pulse gives neither of these and leaves `ready` unchanged.
- R6: `ready` falls at a valid reset. `ready` rises after WAKE_CYC consecutive edges with `rst_n` high, counted from `por_n` release or from the end of the reset. Any low `rst_n` before that point restarts the count.
- R7: `dq_oe` equals `ready` AND `rst_n` AND a read cycle (`ce_n`=0, `oe_n`=0, `we_n`=1). It is therefore 0 on every cycle in which `rst_n` is low.
- R8: While `lockout` is 1, `abort_op` is 1 and no write strobes, including a write already in progress. A rise of `lockout` pulses `force_read` one cycle later. After lockout clears, a write must begin afresh to count.
- R9: Writes are ignored while `ready` is 0 or `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rst_n | input | 1 | Hardware reset pin, active low |
| lockout | input | 1 | Supply below the write-lockout threshold |
| addr | input | ADDR_W | Bus address |
| data | input | DATA_W | Bus write data |
| wr_stb | output | 1 | One-cycle qualified command write |
| wr_addr | output | ADDR_W | Address held for the strobe |
| wr_data | output | DATA_W | Data held for the strobe |
| force_read | output | 1 | Pulse returning the command state machine to read mode |
| abort_op | output | 1 | Stop any program or erase in progress |
| dq_oe | output | 1 | Data pin drive enable |
| ready | output | 1 | Device accessible for reads and writes |

## Verification
Writes are driven as clean pulses of several lengths. These are set against one-edge glitches, which separate a qualified write from a rejected one. Endings by `we_n`, by `ce_n` and by `oe_n` show which edge may close a write, and a data change on the closing edge shows which sample is captured. Writes held through power-up, through a reset wake-up and across a lockout distinguish a write that begins while enabled from one that was merely present. Reset pulses just under and well over the minimum width show where a hardware reset becomes valid, and random mixes of all pins are compared each cycle against a bench model.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

   typedef enum logic [1:0] {
      PH_WAKE = 2'd0,
      PH_RUN  = 2'd1,
      PH_HOLD = 2'd2
   } rst_phase_e;

   function automatic int cnt_width(input int maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/fgd_reset_seq.sv
module fgd_reset_seq
   import flash_guard_pkg::*;
#(
   parameter int RST_MIN_CYC = 50,
   parameter int WAKE_CYC    = 50
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_n,
   input  logic lockout,
   output logic ready,
   output logic in_reset,
   output logic force_read
);
   localparam int LO_W = cnt_width(RST_MIN_CYC);
   localparam int WK_W = cnt_width(WAKE_CYC);
   localparam logic [LO_W-1:0] LO_MAX  = LO_W'(RST_MIN_CYC);
   localparam logic [LO_W-1:0] LO_LAST = LO_W'(RST_MIN_CYC - 1);
   localparam logic [WK_W-1:0] WK_LAST = WK_W'(WAKE_CYC - 1);

   rst_phase_e      phase;
   logic [LO_W-1:0] lo_cnt;
   logic [WK_W-1:0] wk_cnt;
   logic            lock_q;
   logic            fr_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         phase  <= PH_WAKE;
         lo_cnt <= '0;
         wk_cnt <= '0;
         lock_q <= 1'b0;
         fr_q   <= 1'b1;
      end else begin
         lock_q <= lockout;
         fr_q   <= lockout & ~lock_q;
         if (!rst_n) begin
            wk_cnt <= '0;
            if (lo_cnt != LO_MAX) lo_cnt <= lo_cnt + 1'b1;
            if (lo_cnt == LO_LAST) begin
               phase <= PH_HOLD;
               fr_q  <= 1'b1;
            end
         end else begin
            lo_cnt <= '0;
            if (phase != PH_RUN) begin
               if (wk_cnt == WK_LAST) begin
                  phase  <= PH_RUN;
                  wk_cnt <= '0;
               end else begin
                  phase  <= PH_WAKE;
                  wk_cnt <= wk_cnt + 1'b1;
               end
            end
         end
      end
   end

   assign ready      = (phase == PH_RUN);
   assign in_reset   = (phase == PH_HOLD);
   assign force_read = fr_q;

endmodule

// File: rtl/fgd_write_qual.sv
module fgd_write_qual
   import flash_guard_pkg::*;
#(
   parameter int ADDR_W     = 18,
   parameter int DATA_W     = 8,
   parameter int GLITCH_CYC = 1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              enable,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   localparam int MIN_WR = GLITCH_CYC + 1;
   localparam int RUN_W  = cnt_width(MIN_WR);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_WR);

   logic [RUN_W-1:0]  run;
   logic              idle_ok;
   logic              armed;
   logic              act;
   logic [ADDR_W-1:0] h_addr;
   logic [DATA_W-1:0] h_data;

   assign act = ~ce_n & ~we_n & oe_n;

   generate
      if (MIN_WR == 1) begin : g_nofilter
         assign armed = (run != '0);
      end else begin : g_filter
         assign armed = (run == RUN_MAX);
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         run     <= '0;
         idle_ok <= 1'b0;
         wr_stb  <= 1'b0;
         h_addr  <= '0;
         h_data  <= '0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_stb  <= 1'b0;
         idle_ok <= enable & ~act;
         if (!enable) begin
            run <= '0;
         end else if (act) begin
            if ((run != '0) || idle_ok) begin
               if (run != RUN_MAX) run <= run + 1'b1;
               h_addr <= addr;
               h_data <= data;
            end
         end else begin
            if (armed && oe_n) begin
               wr_stb  <= 1'b1;
               wr_addr <= h_addr;
               wr_data <= h_data;
            end
            run <= '0;
         end
      end
   end

endmodule

// File: rtl/fgd_pin_gate.sv
module fgd_pin_gate (
   input  logic ready,
   input  logic in_reset,
   input  logic rst_n,
   input  logic lockout,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   output logic wr_enable,
   output logic dq_oe,
   output logic abort_op
);
   assign wr_enable = ready & rst_n & ~lockout;
   assign dq_oe     = ready & rst_n & ~ce_n & ~oe_n & we_n;
   assign abort_op  = in_reset | lockout;
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
   parameter int ADDR_W      = 18,
   parameter int DATA_W      = 8,
   parameter int GLITCH_CYC  = 1,
   parameter int RST_MIN_CYC = 50,
   parameter int WAKE_CYC    = 50
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              rst_n,
   input  logic              lockout,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              force_read,
   output logic              abort_op,
   output logic              dq_oe,
   output logic              ready
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("flash_guard: bus widths must be at least 1");
      end
      if (GLITCH_CYC < 0) begin : g_bad_glitch
         $error("flash_guard: GLITCH_CYC must not be negative");
      end
      if (RST_MIN_CYC < 1 || WAKE_CYC < 1) begin : g_bad_timing
         $error("flash_guard: reset width and wake-up must be at least 1");
      end
   endgenerate

   logic in_reset;
   logic wr_enable;

   fgd_reset_seq #(
      .RST_MIN_CYC(RST_MIN_CYC),
      .WAKE_CYC   (WAKE_CYC)
   ) u_rst (
      .clk       (clk),
      .por_n     (por_n),
      .rst_n     (rst_n),
      .lockout   (lockout),
      .ready     (ready),
      .in_reset  (in_reset),
      .force_read(force_read)
   );

   fgd_pin_gate u_gate (
      .ready    (ready),
      .in_reset (in_reset),
      .rst_n    (rst_n),
      .lockout  (lockout),
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .wr_enable(wr_enable),
      .dq_oe    (dq_oe),
      .abort_op (abort_op)
   );

   fgd_write_qual #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .GLITCH_CYC(GLITCH_CYC)
   ) u_wq (
      .clk    (clk),
      .por_n  (por_n),
      .enable (wr_enable),
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .we_n   (we_n),
      .addr   (addr),
      .data   (data),
      .wr_stb (wr_stb),
      .wr_addr(wr_addr),
      .wr_data(wr_data)
   );

endmodule

// File: rtl/fgd_checker.sv
module fgd_checker (
   input logic clk,
   input logic por_n,
   input logic oe_n,
   input logic rst_n,
   input logic lockout,
   input logic wr_stb,
   input logic force_read,
   input logic abort_op,
   input logic dq_oe,
   input logic ready
);
   assert_stb_single_R2: assert property (@(posedge clk) disable iff (!por_n)
      wr_stb |=> !wr_stb);

   assert_stb_needs_oe_R3: assert property (@(posedge clk) disable iff (!por_n)
      wr_stb |-> $past(oe_n));

   assert_abort_after_low_R5: assert property (@(posedge clk) disable iff (!por_n)
      (abort_op && !lockout) |-> $past(!rst_n));

   assert_ready_rise_R6: assert property (@(posedge clk) disable iff (!por_n)
      $rose(ready) |-> $past(rst_n));

   assert_dq_off_in_reset_R7: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |-> !dq_oe);

   assert_no_stb_locked_R8: assert property (@(posedge clk) disable iff (!por_n)
      wr_stb |-> !$past(lockout));

   assert_lock_forces_read_R8: assert property (@(posedge clk) disable iff (!por_n)
      $rose(lockout) |=> force_read);

   assert_no_stb_unready_R9: assert property (@(posedge clk) disable iff (!por_n)
      wr_stb |-> ($past(ready) && $past(rst_n)));
endmodule

bind flash_guard fgd_checker u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .oe_n      (oe_n),
   .rst_n     (rst_n),
   .lockout   (lockout),
   .wr_stb    (wr_stb),
   .force_read(force_read),
   .abort_op  (abort_op),
   .dq_oe     (dq_oe),
   .ready     (ready)
);

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
   localparam int AW = 18, DW = 8, GL = 1, RMIN = 50, WK = 50;
   localparam int MINWR = GL + 1;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic por_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rst_n = 1'b1, lockout = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data = '0;
   logic wr_stb, force_read, abort_op, dq_oe, ready;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   flash_guard #(.ADDR_W(AW), .DATA_W(DW), .GLITCH_CYC(GL),
                 .RST_MIN_CYC(RMIN), .WAKE_CYC(WK)) u0 (
      .clk(clk), .por_n(por_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .rst_n(rst_n), .lockout(lockout), .addr(addr), .data(data),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .force_read(force_read), .abort_op(abort_op), .dq_oe(dq_oe), .ready(ready));

   int checks = 0, errors = 0, cycles = 0, stb_seen = 0, fr_seen = 0;
   bit started = 0, done = 0;

   // Bench model: phase 0 wake-up, 1 running, 2 valid reset held
   int m_phase, m_lo, m_wk, m_run;
   bit m_idle, m_stb, m_fr, m_lockq;
   logic [AW-1:0] m_hadr, m_wadr;
   logic [DW-1:0] m_hdat, m_wdat;

   always @(posedge clk) begin
      cycles++;
      if (!por_n) begin
         m_phase = 0; m_lo = 0; m_wk = 0; m_run = 0; m_idle = 0; m_stb = 0;
         m_fr = 1; m_lockq = 0; m_hadr = '0; m_wadr = '0; m_hdat = '0; m_wdat = '0;
         started = 1;
      end else if (started) begin
         bit en, act, act_fr;
         en  = (m_phase == 1) && !lockout && rst_n;
         act = !ce_n && !we_n && oe_n;
         m_stb = 0;
         if (!en) m_run = 0;
         else if (act) begin
            if (m_run > 0 || m_idle) begin
               if (m_run < MINWR) m_run++;
               m_hadr = addr; m_hdat = data;
            end
         end else begin
            if (m_run >= MINWR && oe_n) begin m_stb = 1; m_wadr = m_hadr; m_wdat = m_hdat; end
            m_run = 0;
         end
         m_idle = en && !act;
         act_fr = lockout && !m_lockq;
         m_lockq = lockout;
         if (!rst_n) begin
            m_wk = 0;
            if (m_lo == RMIN - 1) begin m_phase = 2; act_fr = 1; end
            if (m_lo < RMIN) m_lo++;
         end else begin
            m_lo = 0;
            if (m_phase != 1) begin
               if (m_wk == WK - 1) begin m_phase = 1; m_wk = 0; end
               else begin m_phase = 0; m_wk++; end
            end
         end
         m_fr = act_fr;
      end
   end

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   always @(posedge clk) begin
      if (cycles > 150000 && !done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cycles);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit exp_dq();
      return (m_phase == 1) && rst_n && !ce_n && !oe_n && we_n;
   endfunction

   task automatic step();
      @(negedge clk);
      if (started) begin
         chk(wr_stb == m_stb, "R2 wr_stb", wr_stb, m_stb);
         if (m_stb) begin
            chk(wr_addr == m_wadr, "R2 wr_addr", wr_addr, m_wadr);
            chk(wr_data == m_wdat, "R2 wr_data", wr_data, m_wdat);
         end
         chk(force_read == m_fr, "R5 force_read", force_read, m_fr);
         chk(abort_op == ((m_phase == 2) || lockout), "R5 abort_op", abort_op, (m_phase == 2) || lockout);
         chk(ready == (m_phase == 1), "R6 ready", ready, m_phase == 1);
         chk(dq_oe == exp_dq(), "R7 dq_oe", dq_oe, exp_dq());
      end
      stb_seen += int'(wr_stb);
      fr_seen  += int'(force_read);
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic bus(input logic c, input logic o, input logic w);
      ce_n = c; oe_n = o; we_n = w;
   endtask

   // active write of len edges, ended by we_n (by_ce=0) or ce_n (by_ce=1)
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len, input bit by_ce);
      bus(1, 1, 1); step();
      addr = a; data = d; bus(0, 1, 0);
      steps(len);
      if (by_ce) ce_n = 1; else we_n = 1;
      addr = ~a; data = ~d;
      step();
   endtask

   initial begin
      int s0, f0, k;
      void'($urandom(32'h5EED_1234));
      // power-up with a write already active
      bus(0, 1, 0); addr = 18'h1234; data = 8'h5A;
      steps(3);
      chk(!ready, "R1 ready in por", ready, 0);
      chk(!dq_oe, "R1 dq_oe in por", dq_oe, 0);
      chk(!wr_stb, "R1 wr_stb in por", wr_stb, 0);
      chk(force_read, "R1 force_read in por", force_read, 1);
      por_n = 1'b1;
      step();
      chk(!force_read, "R1 force_read after por", force_read, 0);
      steps(WK + 5);
      chk(ready, "R6 ready after wake", ready, 1);
      we_n = 1; steps(2);
      chk(stb_seen == 0, "R4 held write at power-up", stb_seen, 0);

      // clean writes
      s0 = stb_seen;
      do_write(18'h00AAA, 8'hC3, 3, 0);
      chk(wr_stb && wr_data == 8'hC3 && wr_addr == 18'h00AAA, "R2 we_n ended write", wr_data, 8'hC3);
      do_write(18'h15555, 8'h3C, MINWR, 1);
      chk(wr_stb && wr_data == 8'h3C, "R2 ce_n ended write", wr_data, 8'h3C);
      chk(stb_seen == s0 + 2, "R2 strobe count", stb_seen, s0 + 2);

      // glitch and oe-ended writes
      s0 = stb_seen;
      do_write(18'h00001, 8'h11, GL, 0);
      step();
      chk(stb_seen == s0, "R3 glitch rejected", stb_seen, s0);
      bus(1, 1, 1); step(); bus(0, 1, 0); steps(4); oe_n = 0; steps(2); bus(1, 1, 1); steps(2);
      chk(stb_seen == s0, "R3 oe-ended write rejected", stb_seen, s0);

      // read drive and short reset
      bus(0, 0, 1); step();
      chk(dq_oe, "R7 read drives", dq_oe, 1);
      f0 = fr_seen;
      rst_n = 0;
      for (int i = 0; i < RMIN - 1; i++) begin
         step(); chk(!dq_oe, "R7 tri-state in reset", dq_oe, 0);
      end
      rst_n = 1; steps(2);
      chk(fr_seen == f0, "R5 short reset ignored", fr_seen, f0);
      chk(ready, "R5 short reset keeps ready", ready, 1);

      // valid reset and wake-up timing
      rst_n = 0; steps(RMIN + 5);
      chk(fr_seen == f0 + 1, "R5 valid reset pulse", fr_seen, f0 + 1);
      chk(abort_op, "R5 abort while held", abort_op, 1);
      chk(!ready, "R6 ready drops", ready, 0);
      rst_n = 1; k = 0;
      while (!ready && k < WK + 10) begin step(); k++; end
      chk(k == WK, "R6 wake-up length", k, WK);

      // writes during wake-up are ignored; a low blip restarts wake
      rst_n = 0; steps(RMIN + 1); rst_n = 1; s0 = stb_seen;
      do_write(18'h2222, 8'h22, 3, 0);
      chk(stb_seen == s0, "R9 write during wake ignored", stb_seen, s0);
      rst_n = 0; step(); rst_n = 1; k = 0;
      while (!ready && k < WK + 10) begin step(); k++; end
      chk(k == WK, "R6 wake restarts after blip", k, WK);

      // lockout
      s0 = stb_seen; f0 = fr_seen;
      bus(1, 1, 1); step(); bus(0, 1, 0); steps(3);
      lockout = 1; step();
      chk(abort_op, "R8 abort in lockout", abort_op, 1);
      step();
      chk(fr_seen == f0 + 1, "R8 lockout forces read", fr_seen, f0 + 1);
      lockout = 0; steps(3); we_n = 1; steps(2);
      chk(stb_seen == s0, "R8 write across lockout ignored", stb_seen, s0);
      do_write(18'h3F0F0, 8'h77, 2, 0);
      chk(wr_stb && wr_data == 8'h77, "R8 fresh write after lockout", wr_data, 8'h77);

      // random mix compared against the model every cycle
      for (int it = 0; it < 3000; it++) begin
         int r;
         r = int'($urandom % 100);
         if (r < 2) begin
            rst_n = 0; steps(1 + int'($urandom % 70)); rst_n = 1;
         end else if (r < 4) begin
            lockout = 1; steps(1 + int'($urandom % 20)); lockout = 0;
         end else begin
            bus(($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 2) == 0);
            for (int j = 0; j < 1 + int'($urandom % 4); j++) begin
               addr = AW'($urandom); data = DW'($urandom);
               step();
            end
         end
      end
      bus(1, 1, 1); steps(WK + 5);

      done = 1;
      summary();
      $finish;
   end
endmodule